// File: doc/BRIEF.md
# Flash Command Register Sequencer

This block sits between a CPU bus and a flash array controller. The CPU writes command bytes to one write-only register address. The block decodes each byte, keeps the current flash operating mode, and issues one request to the array for each program or erase operation. The array answers with a done pulse. Reads of flash addresses are steered to array data or to verify data, depending on the mode.

Commands act only while reprogramming is valid. That takes both the mode select input and the high-voltage-present input. Two commands are two-byte sequences: the same code written to the command register twice in a row. A single first byte only arms a pending state. Read mode is the default. It holds until another command replaces it.

Top module: `flash_cmd_seq`

## Requirements
- R1: After a hardware reset, `mode_o` is 0 (read mode), `busy`, `arr_req` and `err` are 0.
- R2: A single command write (a write to `CMD_ADDR`) of 0x00, 0x40, 0xC0 or 0xA0 sets `mode_o` to 0 (read), 1 (program-ready), 2 (program verify) or 3 (erase verify). A byte that is not a command code leaves `mode_o` unchanged.
- R3: Two consecutive command writes of 0x20 start an erase: `arr_req` and `busy` rise, `mode_o` becomes 4, and `arr_op` is 1. `arr_addr`/`arr_wdata` carry the second write. A 0x20 followed by any other write starts no erase, and the second byte is decoded as a fresh command. Reads between the two writes do not break the pair.
- R4: Two consecutive command writes of 0xFF return the block to mode 0 and clear `err`. A single 0xFF followed by another byte is decoded as in R2/R3.
- R5: With `bus_rd` high at a flash address, `bus_rdata` equals `arr_rdata` in modes 0, 1 and 4, and `vfy_rdata` in modes 2 and 3.
- R6: A read of `CMD_ADDR` returns 0, whatever was written last.
- R7: In mode 1, a write to a flash address raises `arr_req` with `arr_op` 0 and that address and data. These hold with `busy` (mode 4) until `arr_done` is sampled. The block then returns to mode 1. In modes 0, 2 and 3, flash-address writes have no effect.
- R8: Any write while busy is ignored and sets `err`. `err` stays set until the reset command of R4 or a hardware reset.
- R9: Enable is `mode_sel` AND `vpp_ok`. While it is low, writes are ignored, the next state is mode 0 with no pending byte, and any busy operation is abandoned (`arr_req` low).
- R10: Reads never change the mode. Read mode persists across any number of reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 1 | Reprogramming mode select |
| vpp_ok | input | 1 | High programming voltage present |
| bus_wr | input | 1 | CPU write strobe |
| bus_rd | input | 1 | CPU read strobe |
| bus_addr | input | ADDR_W | CPU address |
| bus_wdata | input | 8 | CPU write data |
| bus_rdata | output | 8 | CPU read data |
| arr_req | output | 1 | Array operation request (level) |
| arr_op | output | 1 | 0 program, 1 erase |
| arr_addr | output | ADDR_W | Operation address |
| arr_wdata | output | 8 | Operation data |
| arr_done | input | 1 | Array operation finished |
| arr_rdata | input | 8 | Array read data |
| vfy_rdata | input | 8 | Verify read data |
| busy | output | 1 | Operation in progress |
| err | output | 1 | Write arrived while busy |
| mode_o | output | 3 | Current mode code |

## Verification
The bench builds the block with `ADDR_W` = 4 and `CMD_ADDR` = 0xF. With these values, every byte value can be swept as the first command write. Each one is paired with every command code, with itself and with a non-code byte. This covers every arming, confirm and abandon path of the two-byte sequences from a known state. The small address space also lets directed steps reach the program path, the read routing in every mode, busy-time writes and enable loss mid-operation in a few cycles.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    typedef logic [7:0] byte_t;

    localparam byte_t CODE_READ  = 8'h00;
    localparam byte_t CODE_PROG  = 8'h40;
    localparam byte_t CODE_PVFY  = 8'hC0;
    localparam byte_t CODE_EVFY  = 8'hA0;
    localparam byte_t CODE_ERASE = 8'h20;
    localparam byte_t CODE_RESET = 8'hFF;

    typedef enum logic [2:0] {
        MODE_READ = 3'd0,
        MODE_PROG = 3'd1,
        MODE_PVFY = 3'd2,
        MODE_EVFY = 3'd3,
        MODE_BUSY = 3'd4
    } mode_e;

    typedef enum logic [1:0] {
        PEND_NONE  = 2'd0,
        PEND_ERASE = 2'd1,
        PEND_RESET = 2'd2
    } pend_e;

    typedef enum logic [3:0] {
        ACT_IGNORE,
        ACT_READ,
        ACT_PROG,
        ACT_PVFY,
        ACT_EVFY,
        ACT_ARM_ERASE,
        ACT_ERASE,
        ACT_ARM_RESET,
        ACT_RESET
    } act_e;

    typedef enum logic {
        OP_PROGRAM = 1'b0,
        OP_ERASE   = 1'b1
    } op_e;

endpackage

// File: rtl/flash_cmd_decode.sv
module flash_cmd_decode
    import flash_cmd_pkg::*;
(
    input  byte_t code,
    input  pend_e pend,
    output act_e  act
);

    always_comb begin
        if (pend == PEND_ERASE && code == CODE_ERASE) begin
            act = ACT_ERASE;
        end else if (pend == PEND_RESET && code == CODE_RESET) begin
            act = ACT_RESET;
        end else begin
            // an unmatched second byte is decoded as a fresh command
            case (code)
                CODE_READ:  act = ACT_READ;
                CODE_PROG:  act = ACT_PROG;
                CODE_PVFY:  act = ACT_PVFY;
                CODE_EVFY:  act = ACT_EVFY;
                CODE_ERASE: act = ACT_ARM_ERASE;
                CODE_RESET: act = ACT_ARM_RESET;
                default:    act = ACT_IGNORE;
            endcase
        end
    end

endmodule

// File: rtl/flash_rd_route.sv
module flash_rd_route
    import flash_cmd_pkg::*;
#(
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] CMD_ADDR = '1
) (
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    input  mode_e             mode,
    input  byte_t             arr_rdata,
    input  byte_t             vfy_rdata,
    output byte_t             rdata
);

    logic hit_cmd;
    logic use_vfy;

    assign hit_cmd = (addr == CMD_ADDR);
    assign use_vfy = (mode == MODE_PVFY) || (mode == MODE_EVFY);

    always_comb begin
        if (!rd || hit_cmd) begin
            rdata = '0;
        end else if (use_vfy) begin
            rdata = vfy_rdata;
        end else begin
            rdata = arr_rdata;
        end
    end

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import flash_cmd_pkg::*;
#(
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] CMD_ADDR = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_sel,
    input  logic              vpp_ok,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              arr_req,
    output logic              arr_op,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [7:0]        arr_wdata,
    input  logic              arr_done,
    input  logic [7:0]        arr_rdata,
    input  logic [7:0]        vfy_rdata,
    output logic              busy,
    output logic              err,
    output logic [2:0]        mode_o
);

    typedef struct packed {
        mode_e             mode;
        mode_e             ret;
        pend_e             pend;
        op_e               op;
        logic [ADDR_W-1:0] addr;
        byte_t             data;
        logic              err;
    } seq_t;

    localparam seq_t SEQ_RESET = '{
        mode: MODE_READ,
        ret:  MODE_READ,
        pend: PEND_NONE,
        op:   OP_PROGRAM,
        addr: '0,
        data: '0,
        err:  1'b0
    };

    seq_t  seq_d, seq_q;
    act_e  act;
    logic  enable;
    logic  is_cmd;

    assign enable = mode_sel & vpp_ok;
    assign is_cmd = (bus_addr == CMD_ADDR);

    flash_cmd_decode i_decode (
        .code (bus_wdata),
        .pend (seq_q.pend),
        .act  (act)
    );

    always_comb begin
        seq_d = seq_q;
        if (!enable) begin
            seq_d.mode = MODE_READ;
            seq_d.pend = PEND_NONE;
        end else if (seq_q.mode == MODE_BUSY) begin
            if (bus_wr) begin
                seq_d.err = 1'b1;
            end
            if (arr_done) begin
                seq_d.mode = seq_q.ret;
            end
        end else if (bus_wr) begin
            seq_d.pend = PEND_NONE;
            if (is_cmd) begin
                case (act)
                    ACT_READ:      seq_d.mode = MODE_READ;
                    ACT_PROG:      seq_d.mode = MODE_PROG;
                    ACT_PVFY:      seq_d.mode = MODE_PVFY;
                    ACT_EVFY:      seq_d.mode = MODE_EVFY;
                    ACT_ARM_ERASE: seq_d.pend = PEND_ERASE;
                    ACT_ARM_RESET: seq_d.pend = PEND_RESET;
                    ACT_ERASE: begin
                        seq_d.mode = MODE_BUSY;
                        seq_d.ret  = MODE_READ;
                        seq_d.op   = OP_ERASE;
                        seq_d.addr = bus_addr;
                        seq_d.data = bus_wdata;
                    end
                    ACT_RESET: begin
                        seq_d.mode = MODE_READ;
                        seq_d.err  = 1'b0;
                    end
                    default: ;
                endcase
            end else if (seq_q.mode == MODE_PROG) begin
                seq_d.mode = MODE_BUSY;
                seq_d.ret  = MODE_PROG;
                seq_d.op   = OP_PROGRAM;
                seq_d.addr = bus_addr;
                seq_d.data = bus_wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= SEQ_RESET;
        end else begin
            seq_q <= seq_d;
        end
    end

    flash_rd_route #(
        .ADDR_W   (ADDR_W),
        .CMD_ADDR (CMD_ADDR)
    ) i_route (
        .rd        (bus_rd),
        .addr      (bus_addr),
        .mode      (seq_q.mode),
        .arr_rdata (arr_rdata),
        .vfy_rdata (vfy_rdata),
        .rdata     (bus_rdata)
    );

    assign busy      = (seq_q.mode == MODE_BUSY);
    assign arr_req   = busy;
    assign arr_op    = seq_q.op;
    assign arr_addr  = seq_q.addr;
    assign arr_wdata = seq_q.data;
    assign err       = seq_q.err;
    assign mode_o    = seq_q.mode;

endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk #(
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] CMD_ADDR = '1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mode_sel,
    input logic              vpp_ok,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [7:0]        bus_rdata,
    input logic              arr_req,
    input logic [ADDR_W-1:0] arr_addr,
    input logic [7:0]        arr_wdata,
    input logic              arr_done,
    input logic              busy,
    input logic              err,
    input logic [2:0]        mode_o
);

    // R9
    enable_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mode_sel && vpp_ok) |=> (mode_o == 3'd0) && !arr_req);

    // R8
    busy_write_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bus_wr && mode_sel && vpp_ok) |=> err);

    // R7
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !arr_done && mode_sel && vpp_ok)
        |=> busy && arr_addr == $past(arr_addr) && arr_wdata == $past(arr_wdata));

    // R6
    cmd_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == CMD_ADDR) |-> bus_rdata == 8'h00);

    // R10
    read_keeps_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel && vpp_ok && !bus_wr && !busy) |=> $stable(mode_o));

endmodule

bind flash_cmd_seq flash_cmd_seq_chk #(
    .ADDR_W   (ADDR_W),
    .CMD_ADDR (CMD_ADDR)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_sel  (mode_sel),
    .vpp_ok    (vpp_ok),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .arr_req   (arr_req),
    .arr_addr  (arr_addr),
    .arr_wdata (arr_wdata),
    .arr_done  (arr_done),
    .busy      (busy),
    .err       (err),
    .mode_o    (mode_o)
);

// File: tb/test_flash_cmd_seq.sv
`timescale 1ns/1ps
module test_flash_cmd_seq;

    localparam int         AW  = 4;
    localparam logic [3:0] CMD = 4'hF;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mode_sel = 1'b1, vpp_ok = 1'b1;
    logic          bus_wr = 1'b0, bus_rd = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [7:0]    bus_wdata = '0;
    logic [7:0]    bus_rdata;
    logic          arr_req, arr_op;
    logic [AW-1:0] arr_addr;
    logic [7:0]    arr_wdata;
    logic          arr_done = 1'b0;
    logic [7:0]    arr_rdata = 8'h3C, vfy_rdata = 8'hC3;
    logic          busy, err;
    logic [2:0]    mode_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // reference model state
    int         m_mode = 0, m_ret = 0, m_pend = 0, m_op = 0;
    logic [3:0] m_addr = '0;
    logic [7:0] m_data = '0;
    bit         m_err = 0;

    always #2.5 clk = ~clk;

    flash_cmd_seq #(.ADDR_W(AW), .CMD_ADDR(CMD)) i_flash_cmd_seq (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .vpp_ok(vpp_ok),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .arr_req(arr_req),
        .arr_op(arr_op), .arr_addr(arr_addr), .arr_wdata(arr_wdata),
        .arr_done(arr_done), .arr_rdata(arr_rdata), .vfy_rdata(vfy_rdata),
        .busy(busy), .err(err), .mode_o(mode_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic chk_state(input string req);
        chk(mode_o == m_mode[2:0], {req, " mode"}, mode_o, m_mode);
        chk(busy == (m_mode == 4), {req, " busy"}, busy, m_mode == 4);
        chk(arr_req == (m_mode == 4), {req, " req"}, arr_req, m_mode == 4);
        chk(err == m_err, {req, " err"}, err, m_err);
        if (m_mode == 4) begin
            chk(arr_op == m_op[0], {req, " op"}, arr_op, m_op);
            chk(arr_addr == m_addr, {req, " addr"}, arr_addr, m_addr);
            chk(arr_wdata == m_data, {req, " data"}, arr_wdata, m_data);
        end
    endtask

    // model of one write, from the requirements
    task automatic model_write(input logic [3:0] a, input logic [7:0] d);
        int was;
        if (m_mode == 4) begin
            m_err = 1;
            return;
        end
        was = m_pend;
        m_pend = 0;
        if (a != CMD) begin
            if (m_mode == 1) begin
                m_mode = 4; m_ret = 1; m_op = 0; m_addr = a; m_data = d;
            end
        end else if (was == 1 && d == 8'h20) begin
            m_mode = 4; m_ret = 0; m_op = 1; m_addr = a; m_data = d;
        end else if (was == 2 && d == 8'hFF) begin
            m_mode = 0; m_err = 0;
        end else begin
            case (d)
                8'h00: m_mode = 0;
                8'h40: m_mode = 1;
                8'hC0: m_mode = 2;
                8'hA0: m_mode = 3;
                8'h20: m_pend = 1;
                8'hFF: m_pend = 2;
                default: ;
            endcase
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        if (mode_sel && vpp_ok) model_write(a, d);
    endtask

    task automatic done_pulse();
        @(negedge clk);
        arr_done = 1'b1;
        @(negedge clk);
        arr_done = 1'b0;
        if (m_mode == 4) m_mode = m_ret;
    endtask

    task automatic drop_enable();
        @(negedge clk);
        vpp_ok = 1'b0;
        @(negedge clk);
        vpp_ok = 1'b1;
        m_mode = 0; m_pend = 0;
    endtask

    task automatic rd_chk(input logic [3:0] a, input logic [7:0] exp, input string req);
        bus_rd = 1'b1; bus_addr = a;
        #1;
        chk(bus_rdata == exp, req, bus_rdata, exp);
        bus_rd = 1'b0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] seconds [8];
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(mode_o == 3'd0 && !busy && !arr_req && !err, "R1", {busy, err, mode_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk_state("R1");

        // R10 repeated reads keep read mode, R5 routing
        for (int i = 0; i < 20; i++) begin
            arr_rdata = 8'(i * 7 + 1);
            rd_chk(4'(i % 15), arr_rdata, "R10 read mode data");
            @(negedge clk);
        end
        chk_state("R10");

        // R6 command address reads as zero
        wr(CMD, 8'hC0);
        rd_chk(CMD, 8'h00, "R6");
        // R5 verify routing in modes 2 and 3
        rd_chk(4'h3, vfy_rdata, "R5 pvfy");
        wr(CMD, 8'hA0);
        chk_state("R2");
        rd_chk(4'h5, vfy_rdata, "R5 evfy");
        // R7 flash write ignored outside program-ready
        wr(4'h2, 8'h11);
        chk_state("R7 ignored");
        wr(CMD, 8'h00);
        wr(4'h2, 8'h11);
        chk_state("R7 ignored read");

        // R7 program flow
        wr(CMD, 8'h40);
        rd_chk(4'h1, arr_rdata, "R5 prog");
        wr(4'h6, 8'h5A);
        chk_state("R7 launch");
        rd_chk(4'h1, arr_rdata, "R5 busy");
        // R8 writes while busy
        wr(CMD, 8'h00);
        chk_state("R8 busy write");
        @(negedge clk);
        chk_state("R7 hold");
        done_pulse();
        chk_state("R7 return");
        // R4 reset command clears err
        wr(CMD, 8'hFF);
        chk_state("R4 armed");
        wr(CMD, 8'hFF);
        chk_state("R4 done");

        // R3 reads between erase bytes do not break the pair
        wr(CMD, 8'h20);
        rd_chk(4'h4, arr_rdata, "R3 read between");
        @(negedge clk);
        wr(CMD, 8'h20);
        chk_state("R3 erase");
        // R9 enable loss aborts busy
        drop_enable();
        chk_state("R9 abort");
        // R9 writes ignored while disabled
        @(negedge clk);
        mode_sel = 1'b0;
        wr(CMD, 8'h40);
        chk(mode_o == 3'd0, "R9 disabled write", mode_o, 0);
        mode_sel = 1'b1;
        @(negedge clk);
        // R9 pending dropped by enable loss
        wr(CMD, 8'h20);
        drop_enable();
        wr(CMD, 8'h20);
        chk_state("R9 pending dropped");
        wr(CMD, 8'h00);

        // R2 R3 R4 sweep of first byte against second bytes
        for (int a = 0; a < 256; a++) begin
            seconds[0] = 8'h00; seconds[1] = 8'h20; seconds[2] = 8'h40;
            seconds[3] = 8'hA0; seconds[4] = 8'hC0; seconds[5] = 8'hFF;
            seconds[6] = 8'(a); seconds[7] = 8'h55;
            for (int b = 0; b < 8; b++) begin
                drop_enable();
                wr(CMD, 8'(a));
                chk_state("R2 first byte");
                wr(CMD, seconds[b]);
                chk_state("R3 R4 second byte");
                if (m_mode == 4) begin
                    done_pulse();
                    chk_state("R3 erase complete");
                end
            end
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule